// File: doc/BRIEF.md
# Two-Wire Byte Memory Slave with Range Write-Protect

This block is a slave on a two-wire serial bus (clock line plus open-drain data line) that gives a bus master byte access to an 8192 x 8 on-chip register array. The master opens a transfer with a START, sends the slave's 7-bit device ID plus a direction bit, and then either loads a 13-bit address pointer and streams data bytes into the array, or streams bytes out of the array from the pointer. Writes land in the same cycle that the byte completes, so no busy or polling period is needed.

A two-bit protect input picks which part of the array refuses writes: nothing, the lowest quarter, the lowest half, or all of it. A data byte whose target is protected is answered with a NACK and leaves the array unchanged. The pointer still moves past it, so the bytes after it land where the master expects. The data pad is modelled as a pull-down enable output and a separate line input. Bus inputs are synchronised to the system clock inside the block.

Top module: `twm_slave`

## Requirements
- R1: The first byte after a START is acknowledged only when its upper 7 bits, sent MSB first, equal DEV_ID (default 7'h50). Its last bit selects the direction (0 = write, 1 = read). After any other ID the slave stays silent until the next START.
- R2: In a write transfer, the two bytes after the ID form the pointer, high byte first. The upper 3 bits of the high byte are ignored, so the pointer is 13 bits wide. Both bytes are acknowledged.
- R3: Each unprotected data byte is acknowledged and stored at the pointer at once. It can be read back in the very next transfer.
- R4: wp_range_i selects the protected range: 2'b00 nothing, 2'b01 addresses 0x0000-0x07FF, 2'b10 addresses 0x0000-0x0FFF, 2'b11 every address. A data byte aimed at a protected address gets no acknowledge and is not stored. Reads are never affected.
- R5: The pointer advances by one after every data byte written (refused bytes included) and after every byte read. It wraps from 0x1FFF to 0x0000.
- R6: In a read transfer, bytes are sent MSB first starting at the pointer, and reading continues while the master acknowledges. A master NACK ends the transfer with the data line released.
- R7: A read transfer with no address phase starts at the current pointer. The pointer is kept across transfers addressed to other device IDs.
- R8: The data line is sampled on rising clock edges. The slave changes its data-line drive only while the clock line is low, after a falling edge.
- R9: A STOP seen at any point, including mid-byte, returns the slave to idle with the data line released, and a partial byte is discarded. A START seen at any point, including mid-byte, restarts the device-ID phase.
- R10: After reset the data line is released and the slave is idle: bytes clocked without a START are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| wp_range_i | input | 2 | Protect range select (see R4) |
| sda_oe_o | output | 1 | 1 = pull the data line low, 0 = release it |

## Verification
Two things fall on the same falling clock edge: the write-or-refuse decision for a data byte and the advance of the pointer. Straddling a protect boundary provokes both in one edge, because the refused byte's pointer advance must bring the next byte onto an unprotected address. The bench writes across the quarter, half and full-array limits. It compares each acknowledge bit, and then the read-back contents of every touched address, against a behavioural memory and pointer model. A second collision, a START or STOP that lands mid-byte, is judged by reading back the target address afterwards and by checking that the next transfer is acknowledged.

// File: rtl/twm_pkg.sv
package twm_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_DEVID, S_ADRH, S_ADRL, S_WDATA, S_ACK, S_RDATA, S_MACK
  } twm_state_e;

  typedef enum logic [1:0] {
    WP_NONE    = 2'b00,
    WP_QUARTER = 2'b01,
    WP_HALF    = 2'b10,
    WP_ALL     = 2'b11
  } wp_range_e;
endpackage

// File: rtl/twm_bus_sense.sv
module twm_bus_sense #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[SYNC-1];
  assign sda_s     = sda_ff[SYNC-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // data moving while the clock stays high marks a bus condition
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twm_prot.sv
module twm_prot
  import twm_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic [AW-1:0] addr,
  input  wp_range_e     range,
  output logic          hit
);
  localparam logic [AW-1:0] QUARTER_LIM = AW'(1) << (AW - 2);
  localparam logic [AW-1:0] HALF_LIM    = AW'(1) << (AW - 1);

  function automatic logic prot_hit_f(input logic [AW-1:0] a, input wp_range_e r);
    case (r)
      WP_NONE:    return 1'b0;
      WP_QUARTER: return a < QUARTER_LIM;
      WP_HALF:    return a < HALF_LIM;
      default:    return 1'b1;
    endcase
  endfunction

  assign hit = prot_hit_f(addr, range);
endmodule

// File: rtl/twm_mem.sv
module twm_mem #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/twm_slave.sv
module twm_slave
  import twm_pkg::*;
#(
  parameter int         AW     = 13,
  parameter logic [6:0] DEV_ID = 7'h50,
  parameter int         SYNC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] wp_range_i,
  output logic       sda_oe_o
);
  localparam int HI_W = AW - 8;
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  function automatic logic [AW-1:0] addr_inc(input logic [AW-1:0] a);
    return a + ONE;
  endfunction

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  twm_state_e    state, after_ack;
  logic [2:0]    bit_cnt;
  logic [7:0]    sh;
  logic [6:0]    tx;
  logic          got_byte, m_ack, sda_pull;
  logic [HI_W-1:0] adr_hi;
  logic [AW-1:0] ptr;
  logic [7:0]    rd_data;
  logic          prot_hit;

  twm_bus_sense #(.SYNC(SYNC)) u_sense (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twm_prot #(.AW(AW)) u_prot (
    .addr(ptr), .range(wp_range_e'(wp_range_i)), .hit(prot_hit)
  );

  // named events
  logic byte_fall, id_match, rx_state, wd_done, mem_we, wd_nack, rd_byte_out;
  assign rx_state    = (state == S_DEVID) || (state == S_ADRH) ||
                       (state == S_ADRL)  || (state == S_WDATA);
  assign byte_fall   = scl_fall & got_byte & rx_state;
  assign id_match    = (sh[7:1] == DEV_ID);
  assign wd_done     = byte_fall & (state == S_WDATA);
  assign mem_we      = wd_done & ~prot_hit;
  assign wd_nack     = wd_done & prot_hit;
  assign rd_byte_out = scl_fall & (state == S_RDATA) & (bit_cnt == 3'd7);

  twm_mem #(.AW(AW), .DW(8)) u_mem (
    .clk(clk), .we(mem_we), .addr(ptr), .wdata(sh), .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      after_ack <= S_IDLE;
      bit_cnt   <= '0;
      sh        <= '0;
      tx        <= '0;
      got_byte  <= 1'b0;
      m_ack     <= 1'b0;
      sda_pull  <= 1'b0;
      adr_hi    <= '0;
      ptr       <= '0;
    end else if (stop_det) begin
      state    <= S_IDLE;
      sda_pull <= 1'b0;
      got_byte <= 1'b0;
    end else if (start_det) begin
      state    <= S_DEVID;
      bit_cnt  <= '0;
      got_byte <= 1'b0;
      sda_pull <= 1'b0;
    end else begin
      case (state)
        S_DEVID, S_ADRH, S_ADRL, S_WDATA: begin
          if (scl_rise) begin
            sh      <= {sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) got_byte <= 1'b1;
          end else if (byte_fall) begin
            got_byte <= 1'b0;
            bit_cnt  <= '0;
            state    <= S_ACK;
            if (state == S_DEVID) begin
              if (id_match) begin
                sda_pull  <= 1'b1;
                after_ack <= sh[0] ? S_RDATA : S_ADRH;
              end else begin
                state <= S_IDLE;
              end
            end else if (state == S_ADRH) begin
              sda_pull  <= 1'b1;
              adr_hi    <= sh[HI_W-1:0];
              after_ack <= S_ADRL;
            end else if (state == S_ADRL) begin
              sda_pull  <= 1'b1;
              ptr       <= {adr_hi, sh};
              after_ack <= S_WDATA;
            end else begin
              sda_pull  <= ~prot_hit;
              ptr       <= addr_inc(ptr);
              after_ack <= S_WDATA;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            state <= after_ack;
            if (after_ack == S_RDATA) begin
              tx       <= rd_data[6:0];
              sda_pull <= ~rd_data[7];
              bit_cnt  <= '0;
            end else begin
              sda_pull <= 1'b0;
            end
          end
        end
        S_RDATA: begin
          if (scl_fall) begin
            if (bit_cnt == 3'd7) begin
              sda_pull <= 1'b0;
              state    <= S_MACK;
              ptr      <= addr_inc(ptr);
            end else begin
              sda_pull <= ~tx[6];
              tx       <= {tx[5:0], 1'b0};
              bit_cnt  <= bit_cnt + 3'd1;
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (m_ack) begin
              tx       <= rd_data[6:0];
              sda_pull <= ~rd_data[7];
              bit_cnt  <= '0;
              state    <= S_RDATA;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_pull;

  // R8: drive changes only follow a low clock
  p_drive_low_clk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !$past(scl_s));
  // R4: stored bytes are acknowledged
  p_write_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (state == S_ACK && sda_pull));
  // R4: refused bytes are not acknowledged
  p_refused_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_nack |=> (state == S_ACK && !sda_pull));
  // R5: pointer steps by one per data byte
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_done || rd_byte_out) |=> (ptr == $past(ptr) + ONE));
  // R9: stop returns to idle with the line released
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == S_IDLE && !sda_pull));
  // R1: a foreign ID leaves the slave silent
  p_foreign_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_fall && state == S_DEVID && !id_match) |=> (state == S_IDLE && !sda_pull));
endmodule

// File: tb/sim_twm_slave.sv
`timescale 1ns/1ps
module sim_twm_slave;
  localparam int Q = 100;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [1:0] wp = 2'b00;
  logic sda_oe;
  wire  sda_bus = m_sda & ~sda_oe;

  always #5 clk = ~clk;

  twm_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .wp_range_i(wp), .sda_oe_o(sda_oe)
  );

  int n_chk = 0;
  int n_fail = 0;
  int r8_viol = 0;
  bit done = 1'b0;
  logic prev_oe = 1'b0;
  byte unsigned ref_mem [8192];
  int ref_ptr = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R8 monitor: drive may only move while the clock line is low
  always @(posedge clk) begin
    if (rst_n && (sda_oe !== prev_oe) && m_scl) r8_viol++;
    prev_oe <= sda_oe;
  end

  function automatic bit ref_prot(input int a, input logic [1:0] r);
    if (r == 2'd0) return 1'b0;
    if (r == 2'd1) return a < 2048;
    if (r == 2'd2) return a < 4096;
    return 1'b1;
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; m_sda = 1'b0; #Q; m_scl = 1'b0; #Q;
  endtask
  task automatic bus_stop();
    m_sda = 1'b0; #Q; m_scl = 1'b1; #Q; m_sda = 1'b1; #Q;
  endtask
  task automatic put_bit(input bit b);
    m_sda = b; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #Q;
  endtask
  task automatic get_bit(output bit b);
    m_sda = 1'b1; #Q; m_scl = 1'b1; #Q; b = sda_bus; #Q; m_scl = 1'b0; #Q;
  endtask
  task automatic send_byte(input logic [7:0] d, output bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(x);
    ack = !x;
  endtask
  task automatic recv_byte(output logic [7:0] d, input bit mack);
    bit x;
    for (int i = 7; i >= 0; i--) begin get_bit(x); d[i] = x; end
    put_bit(!mack);
  endtask

  task automatic addr_phase(input int a, input logic [2:0] junk);
    bit ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack); check("R1 id write", ack, 1);
    send_byte({junk, 5'(a >> 8)}, ack); check("R2 addr hi", ack, 1);
    send_byte(8'(a), ack); check("R2 addr lo", ack, 1);
    ref_ptr = a & 8191;
  endtask

  task automatic model_write(input int a, input logic [2:0] junk, input byte unsigned q[$]);
    bit ack;
    bit exp;
    addr_phase(a, junk);
    foreach (q[i]) begin
      exp = !ref_prot(ref_ptr, wp);
      send_byte(q[i], ack);
      check(exp ? "R3 data ack" : "R4 protected nack", ack, exp);
      if (exp) ref_mem[ref_ptr] = q[i];
      ref_ptr = (ref_ptr + 1) & 8191;
    end
    bus_stop();
  endtask

  task automatic read_body(input int n, input string tag);
    bit ack;
    logic [7:0] d;
    send_byte({DEV, 1'b1}, ack); check("R1 id read", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(d, i != n - 1);
      check(tag, d, ref_mem[ref_ptr]);
      ref_ptr = (ref_ptr + 1) & 8191;
    end
    check("R6 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic read_at(input int a, input int n, input string tag);
    addr_phase(a, 3'b000);
    bus_start();
    read_body(n, tag);
  endtask

  task automatic read_cur(input int n, input string tag);
    bus_start();
    read_body(n, tag);
  endtask

  initial begin
    bit ack;
    #2;
    #50;
    check("R10 released in reset", sda_oe, 0);
    rst_n = 1'b1;
    #(4*Q);
    check("R10 released after reset", sda_oe, 0);
    // R10: a byte with no START is ignored
    m_scl = 1'b0; #Q;
    send_byte({DEV, 1'b0}, ack); check("R10 idle no ack", ack, 0);

    // R3 / R6 basic write then random read
    model_write(16, 3'b000, '{8'hA5, 8'h5A, 8'h3C, 8'h77});
    read_at(16, 3, "R6 read data");
    // R1 foreign ID, then R7 current-address read keeps pointer (0x13)
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, ack); check("R1 foreign id nack", ack, 0);
    send_byte(8'h00, ack); check("R1 silent after foreign id", ack, 0);
    bus_stop();
    read_cur(1, "R7 current read");
    // R2 upper bits of high address byte ignored
    model_write(32, 3'b111, '{8'h96});
    read_at(32, 1, "R2 high bits ignored");
    // R5 wrap
    model_write(8191, 3'b000, '{8'hC1, 8'hC2});
    read_at(8191, 2, "R5 wrap read");
    // R4 protect ranges; preload with no protection
    model_write(2046, 3'b000, '{8'h01, 8'h02, 8'h03});
    model_write(4094, 3'b000, '{8'h04, 8'h05, 8'h06});
    model_write(6144, 3'b000, '{8'h07});
    wp = 2'b01;
    model_write(2046, 3'b000, '{8'hA1, 8'hA2, 8'hA3});
    read_at(2046, 3, "R4 quarter readback");
    wp = 2'b10;
    model_write(4094, 3'b000, '{8'hB1, 8'hB2, 8'hB3});
    read_at(4094, 3, "R4 half readback");
    wp = 2'b11;
    model_write(6144, 3'b000, '{8'hD1});
    read_at(6144, 1, "R4 full readback");
    wp = 2'b00;
    // R9 STOP mid-byte discards the byte
    model_write(48, 3'b000, '{8'h11, 8'h22});
    addr_phase(48, 3'b000);
    put_bit(1); put_bit(0); put_bit(0); put_bit(1);
    bus_stop();
    check("R9 released after stop", sda_oe, 0);
    read_at(48, 1, "R9 stop mid-byte no write");
    // R9 START mid-byte restarts the ID phase (pointer now 0x31)
    addr_phase(49, 3'b000);
    put_bit(0); put_bit(1); put_bit(1);
    bus_start();
    read_body(1, "R9 start mid-byte");
    check("R8 drive only while clock low", r8_viol, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R9 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule